// File: doc/BRIEF.md
# Three-Channel Compare Timer with PWM Outputs

This block is a 16-bit counter shared by three compare channels. Channel 0 sets the period: in modulo mode the counter wraps after it reaches the channel 0 value, and in up/down mode the counter turns around at that value. Channels 1 and 2 drive registered output pins. Each output is set, cleared or toggled when the counter equals the channel's active compare value. Which of these happens depends on a 3-bit action code per channel. With these codes one block can produce edge-aligned PWM, center-aligned PWM, and a complementary pair of outputs with a gap in which both are low.

Compare values arrive as bytes over a small write bus and pass through two stages. A low byte waits in a holding register. Writing the high byte joins the two bytes into a pending word. The pending word becomes the active compare value only on a clock edge where the counter is zero, so a period or duty change never takes effect in the middle of a cycle. The counter advances only on cycles where the `tick` input is high. Each channel has a sticky match flag, and the flags combine with per-channel enables into one registered interrupt line.

Top module: `cmp_timer`

## Requirements
- R1: The counter advances only on clock edges where `tick` is high. Counter mode 0 (`cnt_mode` = 0) counts up freely and wraps from 0xFFFF to 0. Reset leaves count, outputs, flags and `irq` at 0.
- R2: Counter mode 1 (modulo) counts up to the active channel 0 value and then returns to 0, so the period is that value plus one ticks.
- R3: Counter mode 2 (up/down) counts from 0 up to the active channel 0 value, then down to 0, then up again, so the period is twice that value in ticks. If the value is 0, the counter stays at 0.
- R4: Channel n's low byte is written at address 2n and its high byte at address 2n+1. A low-byte write alone changes nothing. The high-byte write forms the pending value {high, held low}.
- R5: The pending value is copied to the active compare value on each clock edge where the counter is 0, and at no other time.
- R6: A match is a tick cycle in which the counter equals the channel's active value. On a match, action code 0 sets the output, 1 clears it and 2 toggles it. The output changes at the edge that ends the matching cycle. Code 3 does nothing.
- R7: In up/down mode, code 4 sets the output on a match while counting up and clears it on a match while counting down. Code 5 does the opposite. With channel 1 on code 4 and channel 2 on code 5, both outputs are low for 2×(C1−C2) of every 2×C0 ticks.
- R8: Code 6 sets the output on a match and clears it on a tick at count 0. Code 7 is the inverse. Outside up/down mode, codes 4 and 5 also act at count 0 (clear and set respectively). A match overrides the zero action. Channel 0 ignores codes 6 and 7.
- R9: A match sets the channel's flag, which stays set until bit n is written as 1 at address 6. If a match and a clear fall on the same cycle, the match wins.
- R10: `irq` is registered. It is high one cycle after any flag is high while its bit in `irq_en` is set.
- R11: Counter mode 3 freezes the counter. It also blocks every match and zero action, even when `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for one cycle |
| cnt_mode | input | 2 | 0 free, 1 modulo, 2 up/down, 3 hold |
| ch_mode | input | 9 | 3-bit action code per channel, channel n at bits 3n+2:3n |
| irq_en | input | 3 | Per-channel interrupt enable |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write address (compare bytes 0..5, flag clear 6) |
| wr_data | input | 8 | Write data |
| count | output | 16 | Current counter value |
| ch_out | output | 3 | Registered channel outputs |
| irq_flag | output | 3 | Sticky match flags |
| irq | output | 1 | Registered interrupt request |

## Verification
Every result of this block appears one edge after its cause. The counter, the outputs and the flags update at the edge that closes the tick cycle. A compare value whose high byte is written at edge k goes live at the first edge after k where the count is 0. `irq` trails the flags by one more edge. The bench's reference model applies exactly these delays at each rising edge, and every output is compared at the following falling edge, so each expected value is checked in the cycle it falls due. The dead-time figure is also counted directly from the pins over one full up/down period.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam logic [1:0] CNT_FREE = 2'd0;
  localparam logic [1:0] CNT_MOD  = 2'd1;
  localparam logic [1:0] CNT_UPDN = 2'd2;
  localparam logic [1:0] CNT_HOLD = 2'd3;

  localparam logic [2:0] OC_SET    = 3'd0;
  localparam logic [2:0] OC_CLR    = 3'd1;
  localparam logic [2:0] OC_TGL    = 3'd2;
  localparam logic [2:0] OC_DIR_HI = 3'd4;
  localparam logic [2:0] OC_DIR_LO = 3'd5;
  localparam logic [2:0] OC_EDGE_HI = 3'd6;
  localparam logic [2:0] OC_EDGE_LO = 3'd7;
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          up
);
  import cmp_timer_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (adv) begin
      case (mode)
        CNT_FREE: begin
          cnt <= cnt + 1'b1;
          up  <= 1'b1;
        end
        CNT_MOD: begin
          cnt <= (cnt >= top) ? '0 : cnt + 1'b1;
          up  <= 1'b1;
        end
        CNT_UPDN: begin
          if (top == '0) begin
            cnt <= '0;
            up  <= 1'b1;
          end else if (up) begin
            if (cnt >= top) begin
              cnt <= cnt - 1'b1;
              up  <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            if (cnt == '0) begin
              cnt <= {{(CW-1){1'b0}}, 1'b1};
              up  <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt)); // R1
  AST_MOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == CNT_MOD && cnt >= top) |=> (cnt == '0)); // R2
  AST_UPDN_RISE: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == CNT_UPDN && up && cnt < top) |=> (cnt == CW'($past(cnt) + 1'b1))); // R3
endmodule

// File: rtl/cmp_timer_cmpreg.sv
module cmp_timer_cmpreg #(
  parameter int BYTE_W = 8,
  localparam int CW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              at_zero,
  output logic [CW-1:0]     active
);
  logic [BYTE_W-1:0] lo_q;
  logic [CW-1:0]     pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      pend_q <= '0;
      active <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) pend_q <= {wr_data, lo_q};
      if (at_zero) active <= pend_q;
    end
  end

  AST_LO_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> $stable(pend_q)); // R4
  AST_LOAD_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> $stable(active)); // R5
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int CW = 16,
  parameter bit IS_PERIOD = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] active,
  input  logic          updn,
  input  logic          up,
  input  logic [2:0]    mode,
  input  logic          clr,
  output logic          out_q,
  output logic          flag_q
);
  import cmp_timer_pkg::*;

  logic hit, at_zero, nxt;
  assign hit     = adv && (cnt == active);
  assign at_zero = adv && (cnt == '0);

  always_comb begin
    nxt = out_q;
    if (at_zero) begin
      case (mode)
        OC_DIR_HI:  if (!updn) nxt = 1'b0;
        OC_DIR_LO:  if (!updn) nxt = 1'b1;
        OC_EDGE_HI: if (!IS_PERIOD) nxt = 1'b0;
        OC_EDGE_LO: if (!IS_PERIOD) nxt = 1'b1;
        default: ;
      endcase
    end
    if (hit) begin
      case (mode)
        OC_SET:     nxt = 1'b1;
        OC_CLR:     nxt = 1'b0;
        OC_TGL:     nxt = ~out_q;
        OC_DIR_HI:  nxt = updn ? up : 1'b1;
        OC_DIR_LO:  nxt = updn ? ~up : 1'b0;
        OC_EDGE_HI: if (!IS_PERIOD) nxt = 1'b1;
        OC_EDGE_LO: if (!IS_PERIOD) nxt = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      out_q <= nxt;
      if (hit) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(out_q)); // R11
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q); // R9

  if (IS_PERIOD) begin : g_period
    AST_NO_EDGE_PWM_CH0: assert property (@(posedge clk) disable iff (rst)
      (mode == OC_EDGE_HI || mode == OC_EDGE_LO) |=> $stable(out_q)); // R8
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int NCH = 3,
  parameter int BYTE_W = 8,
  localparam int CW = 2 * BYTE_W,
  localparam int ADDR_W = $clog2(2 * NCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        cnt_mode,
  input  logic [3*NCH-1:0]  ch_mode,
  input  logic [NCH-1:0]    irq_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CW-1:0]     count,
  output logic [NCH-1:0]    ch_out,
  output logic [NCH-1:0]    irq_flag,
  output logic              irq
);
  import cmp_timer_pkg::*;

  logic          adv, up, at_zero, clr_wr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] act [NCH];

  assign adv     = tick && (cnt_mode != CNT_HOLD);
  assign at_zero = (cnt == '0);
  assign clr_wr  = wr_en && (wr_addr == ADDR_W'(2 * NCH));
  assign count   = cnt;

  cmp_timer_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst(rst), .adv(adv), .mode(cnt_mode),
    .top(act[0]), .cnt(cnt), .up(up)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic lo_sel, hi_sel;
    assign lo_sel = wr_en && (wr_addr == ADDR_W'(2 * c));
    assign hi_sel = wr_en && (wr_addr == ADDR_W'(2 * c + 1));

    cmp_timer_cmpreg #(.BYTE_W(BYTE_W)) u_cmpreg (
      .clk(clk), .rst(rst), .wr_lo(lo_sel), .wr_hi(hi_sel),
      .wr_data(wr_data), .at_zero(at_zero), .active(act[c])
    );

    cmp_timer_chan #(.CW(CW), .IS_PERIOD(c == 0)) u_chan (
      .clk(clk), .rst(rst), .adv(adv), .cnt(cnt), .active(act[c]),
      .updn(cnt_mode == CNT_UPDN), .up(up), .mode(ch_mode[3*c +: 3]),
      .clr(clr_wr && wr_data[c]), .out_q(ch_out[c]), .flag_q(irq_flag[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(irq_flag & irq_en);
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq); // R10
endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cnt_mode = 2'd3;
  logic [8:0] ch_mode = '0;
  logic [2:0] irq_en = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] count;
  logic [2:0]  ch_out, irq_flag;
  logic        irq;

  always #5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst(rst), .tick(tick), .cnt_mode(cnt_mode), .ch_mode(ch_mode),
    .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .ch_out(ch_out), .irq_flag(irq_flag), .irq(irq)
  );

  int vectors = 0, misses = 0;
  bit chk_on = 0, done = 0;
  string phase = "R1";

  int m_cnt, m_up, m_irq;
  int m_lo[3], m_pend[3], m_act[3], m_out[3], m_flag[3];

  // Behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    int adv, top, md, hit, per, o, clr, fl;
    if (rst) begin
      m_cnt = 0; m_up = 1; m_irq = 0;
      for (int c = 0; c < 3; c++) begin
        m_lo[c] = 0; m_pend[c] = 0; m_act[c] = 0; m_out[c] = 0; m_flag[c] = 0;
      end
    end else begin
      adv = (tick && cnt_mode != 2'd3) ? 1 : 0;
      top = m_act[0];
      fl = 0;
      for (int c = 0; c < 3; c++) if (m_flag[c] != 0 && irq_en[c]) fl = 1;
      m_irq = fl;
      for (int c = 0; c < 3; c++) begin
        md = int'(ch_mode[3*c +: 3]);
        per = (c == 0) ? 1 : 0;
        hit = (adv != 0 && m_cnt == m_act[c]) ? 1 : 0;
        o = m_out[c];
        if (adv != 0 && m_cnt == 0) begin
          if (md == 4 && cnt_mode != 2'd2) o = 0;
          if (md == 5 && cnt_mode != 2'd2) o = 1;
          if (md == 6 && per == 0) o = 0;
          if (md == 7 && per == 0) o = 1;
        end
        if (hit != 0) begin
          if (md == 0) o = 1;
          else if (md == 1) o = 0;
          else if (md == 2) o = 1 - o;
          else if (md == 4) o = (cnt_mode == 2'd2) ? m_up : 1;
          else if (md == 5) o = (cnt_mode == 2'd2) ? 1 - m_up : 0;
          else if (md == 6 && per == 0) o = 1;
          else if (md == 7 && per == 0) o = 0;
        end
        m_out[c] = o;
        clr = (wr_en && wr_addr == 3'd6 && wr_data[c]) ? 1 : 0;
        if (hit != 0) m_flag[c] = 1;
        else if (clr != 0) m_flag[c] = 0;
        if (m_cnt == 0) m_act[c] = m_pend[c];
        if (wr_en && wr_addr == 3'(2*c)) m_lo[c] = int'(wr_data);
        if (wr_en && wr_addr == 3'(2*c+1)) m_pend[c] = int'(wr_data) * 256 + m_lo[c];
      end
      if (adv != 0) begin
        case (cnt_mode)
          2'd0: begin m_cnt = (m_cnt + 1) % 65536; m_up = 1; end
          2'd1: begin m_cnt = (m_cnt >= top) ? 0 : m_cnt + 1; m_up = 1; end
          2'd2: begin
            if (top == 0) begin m_cnt = 0; m_up = 1; end
            else if (m_up != 0) begin
              if (m_cnt >= top) begin m_cnt = m_cnt - 1; m_up = 0; end
              else m_cnt = m_cnt + 1;
            end else begin
              if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
              else m_cnt = m_cnt - 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("count", int'(count), m_cnt);
      for (int c = 0; c < 3; c++) begin
        check($sformatf("ch_out[%0d]", c), int'(ch_out[c]), m_out[c]);
        check($sformatf("irq_flag[%0d]", c), int'(irq_flag[c]), m_flag[c]);
      end
      check("irq", int'(irq), m_irq);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_cmp(int ch, int v);
    wr(2*ch, v % 256);
    wr(2*ch + 1, v / 256);
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (gap == 0 || i % gap == 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int both_low;
    repeat (2) @(posedge clk);
    chk_on = 1;
    @(negedge clk); rst = 1'b0;
    phase = "R1"; tick = 1'b1; run(4, 0);

    phase = "R4"; wr(0, 9); cnt_mode = 2'd1; run(20, 0);
    phase = "R2"; wr(1, 0); run(30, 0);
    phase = "R5"; wr_cmp(0, 4); run(30, 0);

    phase = "R6"; ch_mode = {3'd0, 3'd2, 3'd0};
    wr_cmp(1, 2); wr_cmp(2, 3); run(30, 0);
    ch_mode = {3'd1, 3'd2, 3'd3}; run(24, 2);
    tick = 1'b1;

    phase = "R9";
    for (int i = 0; i < 8; i++) begin wr(6, 7); run(1 + i % 3, 0); end
    phase = "R10"; irq_en = 3'b110; run(20, 0);
    wr(6, 7); run(3, 0); irq_en = 3'b000; run(6, 0);

    phase = "R8"; wr_cmp(0, 9); wr_cmp(1, 3); wr_cmp(2, 6);
    ch_mode = {3'd7, 3'd6, 3'd7}; run(40, 0);
    ch_mode = {3'd7, 3'd6, 3'd6}; run(20, 0);

    phase = "R3"; cnt_mode = 2'd2; ch_mode = {3'd5, 3'd4, 3'd0};
    wr_cmp(0, 10); wr_cmp(1, 7); wr_cmp(2, 3); run(80, 0);
    phase = "R7"; both_low = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ch_out[1] == 1'b0 && ch_out[2] == 1'b0) both_low++;
    end
    check("dead-time ticks", both_low, 2 * (7 - 3));

    phase = "R11"; cnt_mode = 2'd3; run(20, 0);

    phase = "R1"; cnt_mode = 2'd0; ch_mode = {3'd0, 3'd2, 3'd0};
    wr_cmp(1, 16'hFFFE); run(66000, 0);
    run(20, 3);
    @(negedge clk); rst = 1'b1; run(2, 0);
    @(negedge clk); rst = 1'b0; run(5, 0);
    finish_run();
  end
endmodule